// File: doc/BRIEF.md
# Subfield Display Timing Controller

This block sequences one display field of a plasma panel that renders gray levels by time division. A field is split into eight subfields. Each subfield has a fixed three-phase cycle. First comes a reset phase. Next is an address phase, which walks through every scan line and presents that line's column on/off pattern. Last is a sustain phase. The number of sustain pulses in that phase grows with the subfield's binary weight. A pixel is lit in a subfield only when the matching bit of its 8-bit intensity is set. The total light a pixel emits over the field is therefore proportional to its intensity code.

The host sets three values: the reset length, the length of the per-line address slot and a base sustain count. The line buffer is read at the address `line_o` and returns all pixels of that line in parallel on `pix_i`. The parameters fix the line count, the column count and the order in which the subfields are played. A field-start strobe that arrives while a field is running is not lost. It is remembered, and the next field begins straight after the current one ends.

Top module: `sf_timing_ctrl`

## Requirements
- R1: After reset `phase_o` is 0 (idle), `busy_o`, `scan_o`, `sus_en_o`, `sus_y_o` and `col_o` are 0, and `line_o` is 0.
- R2: A field start sampled while idle makes `phase_o` equal 1 (reset) in the next cycle. The eight subfields then run in the parameter `SF_ORDER` order, where position p takes index bits [p*3+:3]. Each subfield runs reset (1), then address (2), then sustain (3). After the last sustain cycle of a field, `phase_o` returns to 0.
- R3: The reset phase lasts `reset_len_i` cycles. A value of 0 is treated as 1.
- R4: The address phase visits lines 0 to LINES-1 in ascending order, with `slot_len_i` cycles per line. Values below 2 are treated as 2. `scan_o` is low in the first cycle of each slot and high for the remaining cycles of the slot.
- R5: During the address phase, bit c of `col_o` equals bit k of pixel c of line `line_o`. Pixel c sits at `pix_i[c*8+:8]` and k is `sf_o`. As a result, the column data is valid one cycle before the line's scan strobe. Outside the address phase, `col_o` is 0.
- R6: The sustain phase of subfield k lasts `sus_base_i << k` cycles, and a base of 0 is treated as 1. `sus_en_o` is high in every one of those cycles. `sus_y_o` is high on the 1st, 3rd, 5th and further odd-numbered pulses, and low on the others, so the pulses alternate between Y and X.
- R7: `busy_o` is high from the first reset cycle of a field through its last sustain cycle, and low when idle.
- R8: A field start sampled during a field leaves the running sequence unchanged. A following field then starts with reset in the cycle after the last sustain cycle, with no idle cycle in between. This also holds when the start arrives in that last sustain cycle.
- R9: `sf_o` reports the weight index k of the subfield in progress. When idle it reports the index at order position 0, and `line_o` is 0 outside the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| field_start_i | input | 1 | Field start strobe |
| reset_len_i | input | RST_W | Reset phase length in cycles |
| slot_len_i | input | SLOT_W | Address slot length per line in cycles |
| sus_base_i | input | BASE_W | Sustain base count, shifted left by the weight index |
| pix_i | input | COLS*PIX_W | Intensities of all pixels of line `line_o` |
| phase_o | output | 2 | 0 idle, 1 reset, 2 address, 3 sustain |
| sf_o | output | SF_IW | Weight index of the current subfield |
| line_o | output | LINE_W | Scan line index, also the line buffer read address |
| scan_o | output | 1 | Scan strobe for line `line_o` |
| col_o | output | COLS | Column on/off bits |
| sus_en_o | output | 1 | Sustain pulse enable |
| sus_y_o | output | 1 | High when the current sustain pulse goes to Y, low for X |
| busy_o | output | 1 | A field is in progress |

## Verification
The difficult coincidence is a new field start landing on the cycle in which the running field finishes its last sustain pulse. In that cycle two decisions meet: the end of the field and the acceptance of the new start. The bench drives one start in the middle of a field and a second start on exactly that final sustain cycle. It then checks every cycle against an arithmetic model of two fields placed back to back. The model expects the second field's reset in the very next cycle and exactly one extra field, with no idle gap.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RESET = 2'd1,
    PH_ADDR  = 2'd2,
    PH_SUS   = 2'd3
  } phase_e;
endpackage

// File: rtl/sf_col_slice.sv
module sf_col_slice #(
  parameter int unsigned COLS  = 4,
  parameter int unsigned PIX_W = 8,
  parameter int unsigned SF_IW = 3
) (
  input  logic [COLS*PIX_W-1:0] pix_i,
  input  logic [SF_IW-1:0]      sf_i,
  input  logic                  en_i,
  output logic [COLS-1:0]       col_o
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [PIX_W-1:0] px;
    assign px       = pix_i[c*PIX_W +: PIX_W];
    assign col_o[c] = en_i & px[sf_i];
  end
endmodule

// File: rtl/sf_seq.sv
module sf_seq
  import sf_pkg::*;
#(
  parameter int unsigned NUM_SF   = 8,
  parameter int unsigned SF_IW    = 3,
  parameter logic [NUM_SF*SF_IW-1:0] SF_ORDER = 24'hFAC688,
  parameter int unsigned LINES    = 480,
  parameter int unsigned LINE_W   = 9,
  parameter int unsigned RST_W    = 16,
  parameter int unsigned SLOT_W   = 8,
  parameter int unsigned BASE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              field_start_i,
  input  logic [RST_W-1:0]  reset_len_i,
  input  logic [SLOT_W-1:0] slot_len_i,
  input  logic [BASE_W-1:0] sus_base_i,
  output phase_e            phase_o,
  output logic [SF_IW-1:0]  sf_o,
  output logic [LINE_W-1:0] line_o,
  output logic              scan_o,
  output logic              sus_en_o,
  output logic              sus_y_o,
  output logic              busy_o
);
  localparam int unsigned SUS_W = BASE_W + NUM_SF;
  localparam int unsigned CNT_W = (RST_W > SUS_W) ? RST_W : SUS_W;

  phase_e              phase_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [LINE_W-1:0]   line_q;
  logic [SF_IW-1:0]    pos_q;
  logic                pend_q;

  logic [RST_W-1:0]    rst_eff;
  logic [SLOT_W-1:0]   slot_eff;
  logic [BASE_W-1:0]   base_eff;
  logic [SUS_W-1:0]    sus_total;
  logic [SF_IW-1:0]    k;
  logic rst_last, slot_last, line_last, sus_last, pos_last, field_end, go_next;

  assign rst_eff   = (reset_len_i == '0) ? RST_W'(1) : reset_len_i;
  assign slot_eff  = (slot_len_i < SLOT_W'(2)) ? SLOT_W'(2) : slot_len_i;
  assign base_eff  = (sus_base_i == '0) ? BASE_W'(1) : sus_base_i;
  assign k         = SF_ORDER[pos_q*SF_IW +: SF_IW];
  assign sus_total = SUS_W'(base_eff) << k;

  assign rst_last  = cnt_q == CNT_W'(rst_eff) - CNT_W'(1);
  assign slot_last = slot_q == slot_eff - SLOT_W'(1);
  assign line_last = line_q == LINE_W'(LINES - 1);
  assign sus_last  = cnt_q == CNT_W'(sus_total) - CNT_W'(1);
  assign pos_last  = pos_q == SF_IW'(NUM_SF - 1);
  assign field_end = (phase_q == PH_SUS) && sus_last && pos_last;
  assign go_next   = pend_q | field_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
      line_q  <= '0;
      pos_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      // hold-off of a start seen mid-field
      if (field_end) pend_q <= 1'b0;
      else if (field_start_i && phase_q != PH_IDLE) pend_q <= 1'b1;

      unique case (phase_q)
        PH_IDLE: if (field_start_i) begin
          phase_q <= PH_RESET;
          cnt_q   <= '0;
        end
        PH_RESET: if (rst_last) begin
          phase_q <= PH_ADDR;
          cnt_q   <= '0;
          slot_q  <= '0;
          line_q  <= '0;
        end else cnt_q <= cnt_q + CNT_W'(1);
        PH_ADDR: if (slot_last) begin
          slot_q <= '0;
          if (line_last) begin
            phase_q <= PH_SUS;
            cnt_q   <= '0;
            line_q  <= '0;
          end else line_q <= line_q + LINE_W'(1);
        end else slot_q <= slot_q + SLOT_W'(1);
        PH_SUS: if (sus_last) begin
          cnt_q <= '0;
          if (pos_last) begin
            pos_q   <= '0;
            phase_q <= go_next ? PH_RESET : PH_IDLE;
          end else begin
            pos_q   <= pos_q + SF_IW'(1);
            phase_q <= PH_RESET;
          end
        end else cnt_q <= cnt_q + CNT_W'(1);
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o  = phase_q;
  assign sf_o     = k;
  assign line_o   = line_q;
  assign scan_o   = (phase_q == PH_ADDR) && (slot_q != '0);
  assign sus_en_o = phase_q == PH_SUS;
  assign sus_y_o  = sus_en_o & ~cnt_q[0];
  assign busy_o   = phase_q != PH_IDLE;
endmodule

// File: rtl/sf_timing_ctrl.sv
module sf_timing_ctrl
  import sf_pkg::*;
#(
  parameter int unsigned NUM_SF = 8,
  parameter int unsigned SF_IW  = 3,
  parameter logic [NUM_SF*SF_IW-1:0] SF_ORDER = 24'hFAC688,
  parameter int unsigned LINES  = 480,
  parameter int unsigned COLS   = 16,
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned RST_W  = 16,
  parameter int unsigned SLOT_W = 8,
  parameter int unsigned BASE_W = 8,
  localparam int unsigned LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  field_start_i,
  input  logic [RST_W-1:0]      reset_len_i,
  input  logic [SLOT_W-1:0]     slot_len_i,
  input  logic [BASE_W-1:0]     sus_base_i,
  input  logic [COLS*PIX_W-1:0] pix_i,
  output logic [1:0]            phase_o,
  output logic [SF_IW-1:0]      sf_o,
  output logic [LINE_W-1:0]     line_o,
  output logic                  scan_o,
  output logic [COLS-1:0]       col_o,
  output logic                  sus_en_o,
  output logic                  sus_y_o,
  output logic                  busy_o
);
  phase_e phase;

  sf_seq #(
    .NUM_SF(NUM_SF), .SF_IW(SF_IW), .SF_ORDER(SF_ORDER), .LINES(LINES),
    .LINE_W(LINE_W), .RST_W(RST_W), .SLOT_W(SLOT_W), .BASE_W(BASE_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .field_start_i(field_start_i),
    .reset_len_i(reset_len_i), .slot_len_i(slot_len_i), .sus_base_i(sus_base_i),
    .phase_o(phase), .sf_o(sf_o), .line_o(line_o), .scan_o(scan_o),
    .sus_en_o(sus_en_o), .sus_y_o(sus_y_o), .busy_o(busy_o)
  );

  sf_col_slice #(.COLS(COLS), .PIX_W(PIX_W), .SF_IW(SF_IW)) u_col (
    .pix_i(pix_i), .sf_i(sf_o), .en_i(phase == PH_ADDR), .col_o(col_o)
  );

  assign phase_o = phase;
endmodule

// File: rtl/sf_timing_chk.sv
module sf_timing_chk #(
  parameter int unsigned COLS = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            field_start_i,
  input logic [1:0]      phase_o,
  input logic            scan_o,
  input logic [COLS-1:0] col_o,
  input logic            sus_en_o,
  input logic            sus_y_o,
  input logic            busy_o
);
  assert_scan_in_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_o |-> phase_o == 2'd2);
  assert_col_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o != 2'd2 |-> col_o == '0);
  assert_sus_alt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sus_en_o |=> (!sus_en_o || sus_y_o != $past(sus_y_o)));
  assert_reset_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 2'd1 |=> (phase_o == 2'd1 || phase_o == 2'd2));
  assert_addr_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 2'd2 |=> (phase_o == 2'd2 || phase_o == 2'd3));
  assert_busy_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> phase_o == 2'd1);
  assert_hold_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 2'd3 && field_start_i) |=> busy_o);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == 2'd0 |-> (!sus_en_o && !scan_o && !busy_o));
endmodule

bind sf_timing_ctrl sf_timing_chk #(.COLS(COLS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .field_start_i(field_start_i),
  .phase_o(phase_o), .scan_o(scan_o), .col_o(col_o), .sus_en_o(sus_en_o),
  .sus_y_o(sus_y_o), .busy_o(busy_o)
);

// File: tb/tb_sf_timing_ctrl.sv
`timescale 1ns/1ps
module tb_sf_timing_ctrl;
  localparam int LINES = 3;
  localparam int COLS  = 4;
  localparam int VW    = 15;

  logic clk = 0, rst_ni = 0, field_start = 0;
  logic [15:0] reset_len = 0;
  logic [7:0]  slot_len = 0, sus_base = 0;
  logic [COLS*8-1:0] pix;
  logic [1:0] phase;
  logic [2:0] sf;
  logic [1:0] line;
  logic scan, sus_en, sus_y, busy;
  logic [COLS-1:0] col;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  sf_timing_ctrl #(
    .NUM_SF(8), .SF_IW(3), .SF_ORDER(24'h053977), .LINES(LINES), .COLS(COLS),
    .PIX_W(8), .RST_W(16), .SLOT_W(8), .BASE_W(8)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .field_start_i(field_start),
    .reset_len_i(reset_len), .slot_len_i(slot_len), .sus_base_i(sus_base),
    .pix_i(pix), .phase_o(phase), .sf_o(sf), .line_o(line), .scan_o(scan),
    .col_o(col), .sus_en_o(sus_en), .sus_y_o(sus_y), .busy_o(busy)
  );

  function automatic int pixv(int ln, int c);
    return (ln * 53 + c * 29 + 11) & 255;
  endfunction

  always_comb
    for (int c = 0; c < COLS; c++) pix[c*8 +: 8] = 8'(pixv(int'(line), c));

  // bench order: position p plays weight index 7-p
  function automatic int ord(int p);
    return 7 - p;
  endfunction

  function automatic int flen(int r, int s, int b);
    int re, se, be, tot;
    re = (r == 0) ? 1 : r; se = (s < 2) ? 2 : s; be = (b == 0) ? 1 : b;
    tot = 0;
    for (int p = 0; p < 8; p++) tot += re + LINES * se + (be << ord(p));
    return tot;
  endfunction

  // {busy, sus_y, sus_en, col, scan, line, sf, phase}
  function automatic logic [VW-1:0] expv(int t, int r, int s, int b);
    int re, se, be, k, len, ph, ln, sc, sen, sy, bz;
    logic [COLS-1:0] cl;
    re = (r == 0) ? 1 : r; se = (s < 2) ? 2 : s; be = (b == 0) ? 1 : b;
    ph = 0; ln = 0; sc = 0; sen = 0; sy = 0; bz = 0; cl = '0; k = ord(0);
    if (t >= 0) begin
      for (int p = 0; p < 8; p++) begin
        k = ord(p);
        len = re + LINES * se + (be << k);
        if (t < len) begin
          bz = 1;
          if (t < re) ph = 1;
          else if (t < re + LINES * se) begin
            ph = 2; ln = (t - re) / se; sc = (((t - re) % se) != 0) ? 1 : 0;
            for (int c = 0; c < COLS; c++) cl[c] = 1'((pixv(ln, c) >> k) & 1);
          end else begin
            ph = 3; sen = 1; sy = (((t - re - LINES * se) % 2) == 0) ? 1 : 0;
          end
          break;
        end
        t -= len;
      end
    end
    return {1'(bz), 1'(sy), 1'(sen), cl, 1'(sc), 2'(ln), 3'(k), 2'(ph)};
  endfunction

  task automatic chk(string req, logic [VW-1:0] e);
    logic [VW-1:0] a;
    a = {busy, sus_y, sus_en, col, scan, line, sf, phase};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, a, e);
    end
  endtask

  // nf fields back to back; starts held in at t=mid and on last cycle of first field
  task automatic run(int r, int s, int b, int nf, int mid, string req);
    int f;
    reset_len = 16'(r); slot_len = 8'(s); sus_base = 8'(b);
    f = flen(r, s, b);
    @(negedge clk); field_start = 1;
    @(negedge clk); field_start = 0;
    for (int t = 0; t < nf * f; t++) begin
      chk(req, expv(t % f, r, s, b));
      field_start = (nf > 1 && (t == mid || t == f - 1));
      @(negedge clk);
    end
    field_start = 0;
    for (int i = 0; i < 3; i++) begin
      chk(req, expv(-1, r, s, b));
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", expv(-1, 0, 0, 0));
    rst_ni = 1;
    @(negedge clk);
    chk("R1", expv(-1, 0, 0, 0));
    run(2, 3, 1, 1, -1, "R2 R4 R5 R6 R9");
    run(0, 1, 0, 1, -1, "R3 R4 R6");
    run(5, 4, 3, 1, -1, "R3 R5 R6 R7");
    run(2, 3, 1, 2, 50, "R8 R7");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule